// File: doc/BRIEF.md
# Highway and Farm-Road Intersection Signal Controller

This block sequences the lamps at a crossing between a busy highway and a quiet farm road. The highway shows green by default. The farm road gets a green phase only when a vehicle sensor reports a waiting car and the highway has already held green for a full long interval. The farm-road green then lasts only while cars remain, and never longer than one long interval. Each change of green passes through a yellow phase that lasts one short interval.

A built-in interval counter times both intervals. The controller emits a one-cycle restart pulse on every phase change. That pulse clears the counter, so each phase is timed from its own start. The short and long interval lengths are parameters given in clock cycles. The restart pulse and both interval flags are brought out as outputs, so the sequence can be observed.

Top module: `xroad_light_ctrl`

## Requirements
- R1: Each road drives a 2-bit lamp code: green is 2'b00, yellow is 2'b01 and red is 2'b10. In every phase at least one road shows red.
- R2: A synchronous active-low reset puts the controller in highway green / farm red and clears the counter, so both interval flags read 0 while reset is held.
- R3: In highway green, the controller moves to highway yellow only in a cycle where `car_waiting` and `long_elapsed` are both 1. Otherwise it stays in highway green, even with a car waiting.
- R4: In highway yellow, the controller moves to farm green in the first cycle where `short_elapsed` is 1. Otherwise it stays.
- R5: In farm green, the controller moves to farm yellow in any cycle where `long_elapsed` is 1 or `car_waiting` is 0. Otherwise it stays.
- R6: In farm yellow, the controller returns to highway green in the first cycle where `short_elapsed` is 1. Otherwise it stays.
- R7: After a restart pulse the counter counts clock cycles from 0. `short_elapsed` is 1 once the count reaches SHORT_CYC, and `long_elapsed` is 1 once it reaches LONG_CYC. Each flag then stays 1 until the next restart.
- R8: `timer_start` is 1 in exactly those cycles whose following clock edge changes the phase, and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| car_waiting | input | 1 | Farm-road vehicle sensor, 1 when a car is present |
| hwy_lamp | output | 2 | Highway lamp code (00 green, 01 yellow, 10 red) |
| farm_lamp | output | 2 | Farm-road lamp code (00 green, 01 yellow, 10 red) |
| timer_start | output | 1 | Restart pulse, high in the cycle before a phase change |
| short_elapsed | output | 1 | Short interval has passed since the last restart |
| long_elapsed | output | 1 | Long interval has passed since the last restart |

## Verification
The lamp codes are decoded from the phase register, and `timer_start` is a combinational function of the phase and inputs, so a new phase becomes visible one clock after the cycle in which `timer_start` is high. The interval flags rise in the cycle when the count reaches its limit: SHORT_CYC clock edges after the edge that took the restart, or after reset release. A yellow phase therefore lasts SHORT_CYC+1 cycles. The bench drives the sensor at the falling edge and samples every output one time unit later. Its vector table lists the expected value for every cycle, so each transition is checked in the exact cycle it is due.

// File: rtl/xroad_pkg.sv
// Shared types for the intersection controller.
// Assumes: the phase is held one-hot; lamp codes are fixed by the lamp interface.
package xroad_pkg;

    typedef enum logic [3:0] {
        PH_HWY_GO    = 4'b0001,
        PH_HWY_WARN  = 4'b0010,
        PH_FARM_GO   = 4'b0100,
        PH_FARM_WARN = 4'b1000
    } phase_t;

    typedef enum logic [1:0] {
        LAMP_GREEN  = 2'b00,
        LAMP_YELLOW = 2'b01,
        LAMP_RED    = 2'b10
    } lamp_t;

endpackage

// File: rtl/xroad_timer.sv
// Interval counter: clears on restart, counts cycles, and saturates at LONG_CYC.
// Assumes: 1 <= SHORT_CYC < LONG_CYC; restart comes from the phase sequencer.
module xroad_timer #(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic short_up,
    output logic long_up
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

    logic [CNT_W-1:0] cnt;

    // Count cycles since the last restart, holding at the long limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (cnt != LONG_LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Compare the count against both limits.
    always_comb begin
        short_up = (cnt >= SHORT_LIM);
        long_up  = (cnt >= LONG_LIM);
    end

    // R7: the restart clears the count below the short limit
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !short_up);
    // R7: the long flag implies the short flag
    p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        long_up |-> short_up);
    // R7: the long flag holds until a restart
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (long_up && !restart) |=> long_up);

endmodule

// File: rtl/xroad_seq.sv
// Phase sequencer: a one-hot four-phase machine with a Mealy restart pulse.
// Assumes: the interval flags come from xroad_timer. Any illegal phase code
// recovers to highway green and pulses restart.
module xroad_seq
    import xroad_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car,
    input  logic   short_up,
    input  logic   long_up,
    output phase_t phase,
    output logic   restart
);
    phase_t nxt;

    // Choose the next phase and raise restart on every change.
    always_comb begin
        nxt     = phase;
        restart = 1'b0;
        case (phase)
            PH_HWY_GO: begin
                if (car && long_up) begin
                    nxt     = PH_HWY_WARN;
                    restart = 1'b1;
                end
            end
            PH_HWY_WARN: begin
                if (short_up) begin
                    nxt     = PH_FARM_GO;
                    restart = 1'b1;
                end
            end
            PH_FARM_GO: begin
                if (long_up || !car) begin
                    nxt     = PH_FARM_WARN;
                    restart = 1'b1;
                end
            end
            PH_FARM_WARN: begin
                if (short_up) begin
                    nxt     = PH_HWY_GO;
                    restart = 1'b1;
                end
            end
            default: begin
                nxt     = PH_HWY_GO;
                restart = 1'b1;
            end
        endcase
    end

    // Phase register with synchronous reset to highway green.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_HWY_GO;
        end else begin
            phase <= nxt;
        end
    end

    // R3: highway green is left only with a car waiting and the long interval over
    p_hwy_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_GO && restart) |-> (car && long_up));
    // R4: highway yellow is left only after the short interval
    p_hwy_warn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_WARN && restart) |-> short_up);
    // R5: farm green is left on the long interval or when no car is waiting
    p_farm_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FARM_GO && !restart) |-> (car && !long_up));
    // R6: farm yellow is left only after the short interval
    p_farm_warn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FARM_WARN && restart) |-> short_up);
    // R8: a restart pulse is followed by a phase change
    p_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase != $past(phase)));
    // R8: without a restart pulse the phase holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(phase));

endmodule

// File: rtl/xroad_lamps.sv
// Lamp decoder: maps the phase to highway and farm lamp codes (a Moore output).
// Assumes: the phase is one-hot; any other code shows red on both roads.
module xroad_lamps
    import xroad_pkg::*;
(
    input  phase_t      phase,
    output logic [1:0]  hwy,
    output logic [1:0]  farm
);
    // Decode each phase into the pair of lamp colours.
    always_comb begin
        case (phase)
            PH_HWY_GO:    begin hwy = LAMP_GREEN;  farm = LAMP_RED;    end
            PH_HWY_WARN:  begin hwy = LAMP_YELLOW; farm = LAMP_RED;    end
            PH_FARM_GO:   begin hwy = LAMP_RED;    farm = LAMP_GREEN;  end
            PH_FARM_WARN: begin hwy = LAMP_RED;    farm = LAMP_YELLOW; end
            default:      begin hwy = LAMP_RED;    farm = LAMP_RED;    end
        endcase
    end

    // R1: one road is red whenever the phase is known.
    always_comb begin
        if (!$isunknown(phase)) begin
            p_one_red_r1: assert (hwy == LAMP_RED || farm == LAMP_RED);
        end
    end

endmodule

// File: rtl/xroad_light_ctrl.sv
// Intersection controller top: connects the sequencer, interval counter and lamp decoder.
// Assumes: car_waiting is synchronous to clk; interval lengths are given in cycles.
module xroad_light_ctrl
    import xroad_pkg::*;
#(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       car_waiting,
    output logic [1:0] hwy_lamp,
    output logic [1:0] farm_lamp,
    output logic       timer_start,
    output logic       short_elapsed,
    output logic       long_elapsed
);
    phase_t phase;
    logic   restart;
    logic   short_up;
    logic   long_up;

    xroad_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .car      (car_waiting),
        .short_up (short_up),
        .long_up  (long_up),
        .phase    (phase),
        .restart  (restart)
    );

    xroad_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .short_up (short_up),
        .long_up  (long_up)
    );

    xroad_lamps u_lamps (
        .phase (phase),
        .hwy   (hwy_lamp),
        .farm  (farm_lamp)
    );

    // Drive the observable timing signals.
    always_comb begin
        timer_start   = restart;
        short_elapsed = short_up;
        long_elapsed  = long_up;
    end

endmodule

// File: tb/xroad_light_ctrl_tb.sv
// Self-checking bench: a per-cycle vector table, then directed reset and saturation tests.
module xroad_light_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT_T    = 2;
    localparam int LONG_T     = 5;
    localparam int NVEC       = 33;

    // Vector fields: [7] car, [6:5] hwy, [4:3] farm, [2] start, [1] short, [0] long
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'b0_00_10_000, 8'b1_00_10_000, 8'b1_00_10_010, 8'b1_00_10_010,
        8'b1_00_10_010, 8'b0_00_10_011, 8'b1_00_10_111, 8'b1_01_10_000,
        8'b1_01_10_000, 8'b1_01_10_110, 8'b1_10_00_000, 8'b1_10_00_000,
        8'b1_10_00_010, 8'b1_10_00_010, 8'b1_10_00_010, 8'b1_10_00_111,
        8'b1_10_01_000, 8'b1_10_01_000, 8'b1_10_01_110, 8'b1_00_10_000,
        8'b1_00_10_000, 8'b1_00_10_010, 8'b1_00_10_010, 8'b1_00_10_010,
        8'b1_00_10_111, 8'b0_01_10_000, 8'b0_01_10_000, 8'b0_01_10_110,
        8'b0_10_00_100, 8'b1_10_01_000, 8'b1_10_01_000, 8'b1_10_01_110,
        8'b1_00_10_000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       car = 1'b0;
    logic [1:0] hwy_lamp;
    logic [1:0] farm_lamp;
    logic       timer_start;
    logic       short_elapsed;
    logic       long_elapsed;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xroad_light_ctrl #(
        .SHORT_CYC (SHORT_T),
        .LONG_CYC  (LONG_T)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .car_waiting   (car),
        .hwy_lamp      (hwy_lamp),
        .farm_lamp     (farm_lamp),
        .timer_start   (timer_start),
        .short_elapsed (short_elapsed),
        .long_elapsed  (long_elapsed)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string phase_req(input logic [1:0] h, input logic [1:0] f);
        if (h == 2'b00) return "R3";
        if (h == 2'b01) return "R4";
        if (f == 2'b00) return "R5";
        return "R6";
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        // R2: outputs while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", "reset lamps", {4'b0, hwy_lamp, farm_lamp}, 8'b0000_0010);
        chk("R2", "reset flags", {6'b0, short_elapsed, long_elapsed}, 8'd0);

        // Main vector walk: one vector per cycle, from reset release
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            car = VEC[i][7];
            #1;
            chk("R1", $sformatf("lamps v%0d (%s)", i, phase_req(VEC[i][6:5], VEC[i][4:3])),
                {4'b0, hwy_lamp, farm_lamp}, {4'b0, VEC[i][6:3]});
            chk("R8", $sformatf("start v%0d (%s)", i, phase_req(VEC[i][6:5], VEC[i][4:3])),
                {7'b0, timer_start}, {7'b0, VEC[i][2]});
            chk("R7", $sformatf("flags v%0d", i),
                {6'b0, short_elapsed, long_elapsed}, {6'b0, VEC[i][1:0]});
            @(negedge clk);
        end

        // R3: with no car, highway green holds and the long flag stays saturated
        car = 1'b0;
        repeat (12) @(negedge clk);
        #1;
        chk("R3", "hold green no car", {4'b0, hwy_lamp, farm_lamp}, 8'b0000_0010);
        chk("R7", "long saturates", {6'b0, short_elapsed, long_elapsed}, 8'b11);
        chk("R8", "no start no car", {7'b0, timer_start}, 8'd0);

        // R2: reset during farm green returns to highway green
        car = 1'b1;
        for (int k = 0; k < 20 && farm_lamp != 2'b00; k++) @(negedge clk);
        #1;
        chk("R5", "reached farm green", {6'b0, farm_lamp}, 8'b00);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R2", "mid reset lamps", {4'b0, hwy_lamp, farm_lamp}, 8'b0000_0010);
        chk("R2", "mid reset flags", {6'b0, short_elapsed, long_elapsed}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R3", "min green after reset", {7'b0, timer_start}, 8'd0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

endmodule